// File: doc/BRIEF.md
# Shift-Add Constant Multiplier with Rounded Descale

This block multiplies a signed two's-complement operand by a fixed real constant chosen at elaboration, such as 1/ln(2) or ln(2). It uses no hardware multiplier. The constant is scaled by 2^SCALE and rounded to the nearest integer. That integer is then recoded into canonical signed digits, in which no two neighbouring digits are both non-zero.

Each non-zero digit adds or subtracts one shifted copy of the operand. The wide sum is brought back to the operand's scale by a right shift of SCALE bits, and that shift rounds to nearest instead of truncating.

A typical use is range reduction for an exponential unit. There x/ln(2) is formed first and later split into an integer part, which adjusts the exponent, and a fraction. The operand and the product each carry a valid bit. A LATENCY parameter of 0, 1 or 2 places registers after the term sum and after the descale.

Top module: `csd_const_mult`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, out_vld is 0. With LATENCY above 0, out_prod is also 0.
- R2: The quantized constant is CQ = floor(CONST_VAL * 2^SCALE + 0.5), which is round to nearest and not truncation.
- R3: For every valid operand x, out_prod = floor((x*CQ + 2^(SCALE-1)) / 2^SCALE). This is round-half-up on the signed value, presented as a signed DW+1 bit result.
- R4: The operands -2^(DW-1), 2^(DW-1)-1, -1, 0 and 1 give the exact result of R3 without wrap-around.
- R5: out_vld goes high exactly LATENCY clock cycles after in_vld was sampled high, together with that operand's product. With LATENCY 0 the path is combinational.
- R6: A new operand is accepted on every cycle, and results leave in the order their operands arrived.
- R7: For a cycle with in_vld low, the matching output cycle has out_vld low. With LATENCY above 0, out_prod holds the last product through such bubbles.
- R8: The internal shift-add sum never needs more than DW+SCALE+1 signed bits, so the DW+SCALE+2 bit accumulator cannot overflow.
- R9: A non-negative operand gives a non-negative product, and a negative operand gives a product of zero or less.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operand qualifier |
| in_op | input | DW | Signed operand |
| out_vld | output | 1 | Product qualifier |
| out_prod | output | DW+1 | Signed rounded product |

## Verification
The assertions check three things on every cycle:
- each register stage passes its valid bit forward with exactly one cycle of delay and holds its data during bubbles;
- the shift-add sum keeps a spare sign bit;
- the sign of the rounded result follows the sign of the operand.

Only the bench scenarios can show that the numeric value is correct. They compare results against an independently computed reference, over random operands, the extreme operands and both constants. The rounding of the quantized constant only becomes visible through an operand that the bench searches for, one whose result would change if the constant were truncated.

// File: rtl/csdm_pkg.sv
package csdm_pkg;

    // Scale a positive real constant by 2^s and round to the nearest integer.
    function automatic longint quantize(real c, int s);
        real sc;
        sc = 1.0;
        for (int i = 0; i < s; i++) sc = sc * 2.0;
        return longint'($floor(c * sc + 0.5));
    endfunction

    // Signed digit (-1, 0 or +1) at position pos of the canonical recoding of q.
    // Neighbouring non-zero digits never occur, because an odd residue is
    // always pushed to a multiple of four before the next shift.
    function automatic int csd_digit(longint q, int pos);
        longint r;
        int     d;
        r = q;
        d = 0;
        for (int i = 0; i <= pos; i++) begin
            if (r[0]) d = r[1] ? -1 : 1;
            else      d = 0;
            r = (r - longint'(d)) >>> 1;
        end
        return d;
    endfunction

endpackage

// File: rtl/csdm_shift_add.sv
module csdm_shift_add
    import csdm_pkg::*;
#(
    parameter int     DW    = 16,
    parameter int     SCALE = 18,
    parameter longint CQ    = 64'd378194,
    localparam int    SW    = DW + SCALE + 2,
    localparam int    NPOS  = SCALE + 2
) (
    input  logic signed [DW-1:0] x_i,
    output logic signed [SW-1:0] sum_o
);

    logic signed [SW-1:0] xe;
    logic signed [SW-1:0] psum [0:NPOS];

    assign xe      = SW'(x_i);
    assign psum[0] = '0;

    for (genvar p = 0; p < NPOS; p++) begin : g_pos
        localparam int DIG = csd_digit(CQ, p);
        if (DIG == 1) begin : g_add
            assign psum[p+1] = psum[p] + (xe <<< p);
        end else if (DIG == -1) begin : g_sub
            assign psum[p+1] = psum[p] - (xe <<< p);
        end else begin : g_skip
            assign psum[p+1] = psum[p];
        end
    end

    assign sum_o = psum[NPOS];

endmodule

// File: rtl/csdm_descale.sv
module csdm_descale #(
    parameter int  SW    = 36,
    parameter int  SCALE = 18,
    parameter int  OW    = 17
) (
    input  logic signed [SW-1:0] sum_i,
    output logic signed [OW-1:0] res_o
);

    localparam logic signed [SW-1:0] HALF = SW'(1) <<< (SCALE - 1);

    logic signed [SW-1:0] biased;

    assign biased = sum_i + HALF;
    assign res_o  = OW'(biased >>> SCALE);

endmodule

// File: rtl/csdm_pipe.sv
module csdm_pipe #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         vld_i,
    input  logic [W-1:0] dat_i,
    output logic         vld_o,
    output logic [W-1:0] dat_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
            dat_o <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) dat_o <= dat_i;
        end
    end

    AST_VLD_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> vld_o == $past(vld_i)); // R5

    AST_DAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(vld_i)) |-> $stable(dat_o)); // R7

endmodule

// File: rtl/csd_const_mult.sv
module csd_const_mult
    import csdm_pkg::*;
#(
    parameter int  DW        = 16,
    parameter int  SCALE     = 18,
    parameter real CONST_VAL = 1.4426950408889634,
    parameter int  LATENCY   = 2,
    localparam int SW        = DW + SCALE + 2,
    localparam int OW        = DW + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_vld,
    input  logic signed [DW-1:0] in_op,
    output logic                 out_vld,
    output logic signed [OW-1:0] out_prod
);

    localparam longint CQ = quantize(CONST_VAL, SCALE);

    typedef struct packed {
        logic                 neg;
        logic signed [SW-1:0] sum;
    } mid_t;

    mid_t                 mid_c, mid_a;
    logic                 vld_a;
    logic signed [OW-1:0] res_c;

    csdm_shift_add #(.DW(DW), .SCALE(SCALE), .CQ(CQ)) u_tree (
        .x_i   (in_op),
        .sum_o (mid_c.sum)
    );
    assign mid_c.neg = in_op[DW-1];

    if (LATENCY >= 1) begin : g_reg_a
        csdm_pipe #(.W($bits(mid_t))) u_pa (
            .clk(clk), .rst(rst), .vld_i(in_vld), .dat_i(mid_c),
            .vld_o(vld_a), .dat_o(mid_a)
        );
    end else begin : g_wire_a
        assign vld_a = in_vld;
        assign mid_a = mid_c;
    end

    csdm_descale #(.SW(SW), .SCALE(SCALE), .OW(OW)) u_desc (
        .sum_i (mid_a.sum),
        .res_o (res_c)
    );

    if (LATENCY >= 2) begin : g_reg_b
        csdm_pipe #(.W(OW)) u_pb (
            .clk(clk), .rst(rst), .vld_i(vld_a), .dat_i(res_c),
            .vld_o(out_vld), .dat_o(out_prod)
        );
    end else begin : g_wire_b
        assign out_vld  = vld_a;
        assign out_prod = res_c;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        vld_a |-> mid_a.sum[SW-1] == mid_a.sum[SW-2]); // R8

    AST_SIGN_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        vld_a |-> (mid_a.neg ? (res_c <= 0) : (res_c >= 0))); // R9

endmodule

// File: tb/sim_csd_const_mult.sv
`timescale 1ns/1ps
module sim_csd_const_mult;

    localparam int  DW = 16;
    localparam int  SC = 18;
    localparam real C0 = 1.4426950408889634;
    localparam real C1 = 0.6931471805599453;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_vld = 1'b0;
    logic signed [DW-1:0] in_op = '0;
    logic o0_vld, o1_vld;
    logic signed [DW:0] o0_prod, o1_prod;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    csd_const_mult #(.DW(DW), .SCALE(SC), .CONST_VAL(C0), .LATENCY(2)) u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_op(in_op),
        .out_vld(o0_vld), .out_prod(o0_prod)
    );

    csd_const_mult #(.DW(DW), .SCALE(SC), .CONST_VAL(C1), .LATENCY(0)) u1 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_op(in_op),
        .out_vld(o1_vld), .out_prod(o1_prod)
    );

    function automatic longint cq_of(real c);
        real s = 1.0;
        for (int i = 0; i < SC; i++) s = s * 2.0;
        return longint'($floor(c * s + 0.5));
    endfunction

    function automatic longint ref_prod(longint x, longint cq);
        longint p = x * cq + (longint'(1) <<< (SC - 1));
        return p >>> SC;
    endfunction

    longint cq0, cq1;
    bit     hv [0:1];
    longint hd [0:1];
    longint last0;

    task automatic chk(input string req, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one cycle: check the latency-2 unit, advance history, drive, check the
    // combinational unit
    task automatic step(input bit v, input longint x, input string req);
        @(negedge clk);
        chk(hv[1] ? "R5" : "R7", longint'(o0_vld), longint'(hv[1]));
        if (hv[1]) begin
            chk(req, longint'(o0_prod), hd[1]);
            last0 = hd[1];
        end else begin
            chk("R7", longint'(o0_prod), last0);
        end
        hv[1] = hv[0]; hd[1] = hd[0];
        hv[0] = v;     hd[0] = ref_prod(x, cq0);
        in_vld = v;
        in_op  = DW'(x);
        #1;
        chk("R5", longint'(o1_vld), longint'(v));
        if (v) begin
            chk(req, longint'(o1_prod), ref_prod(x, cq1));
            if (x >= 0) chk("R9", longint'(o1_prod >= 0), 1);
            else        chk("R9", longint'(o1_prod <= 0), 1);
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        longint xr;
        cq0 = cq_of(C0);
        cq1 = cq_of(C1);
        hv[0] = 0; hv[1] = 0; hd[0] = 0; hd[1] = 0; last0 = 0;
        void'($urandom(32'd1234));

        // R1: outputs quiet under reset even with a valid operand present
        rst = 1'b1; in_vld = 1'b1; in_op = 16'sd1000;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R1", longint'(o0_vld), 0);
            chk("R1", longint'(o0_prod), 0);
        end
        in_vld = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", longint'(o0_vld), 0);
        chk("R1", longint'(o0_prod), 0);

        // R2: an operand whose result differs between a rounded and truncated constant
        xr = 0;
        for (longint x = 32767; x > 0; x--) begin
            if (ref_prod(x, cq0) != ref_prod(x, cq0 - 1)) begin
                xr = x;
                break;
            end
        end
        chk("R2", longint'(xr != 0), 1);
        step(1, xr, "R2");
        step(1, -xr, "R2");

        // R4 / R8: extremes
        step(1, -32768, "R4");
        step(1, 32767, "R4");
        step(1, -1, "R4");
        step(1, 0, "R4");
        step(1, 1, "R8");
        step(1, -32768, "R8");

        // R7: bubbles
        step(0, 5, "R7");
        step(0, 6, "R7");
        step(0, 7, "R7");

        // R6: back-to-back stream of distinct values
        for (int i = 0; i < 12; i++) step(1, longint'(i * 2731 - 16000), "R6");

        // R3: random operands with random gaps
        for (int i = 0; i < 400; i++) begin
            bit v;
            logic signed [15:0] r;
            v = ($urandom % 4) != 0;
            r = 16'($urandom);
            step(v, longint'(r), "R3");
        end

        // drain the pipeline
        for (int i = 0; i < 4; i++) step(0, 0, "R7");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule